// File: doc/BRIEF.md
# Polled UART Peripheral

This block is a serial port that sits on a simple memory bus and is driven entirely by polling. There is no interrupt and no transmit queue. To send a byte, software writes the byte into a holding register and then writes a start command. It then polls a ready flag before the next send. The transmitter serializes the byte as an 8N1 frame on the line: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts a fixed number of clock cycles, set by a parameter.

The receive line passes through a chain of synchronizer flops before the receiver uses it. The receiver detects a falling edge, confirms the start bit at its middle, and then samples each data bit at mid-bit. A byte whose stop bit is good is pushed into a small receive FIFO. Software drains the FIFO through a data register, and each read of that register removes one entry. Three further registers report the FIFO state: the occupancy, an almost-empty flag that is set when exactly one byte is held, and an empty flag.

Bus accesses complete in the cycle they are presented. Read data is combinational from the address. Any write or pop caused by an access takes effect at the clock edge that ends that cycle.

Top module: `uart_poll_top`

## Requirements
- R1: After reset the line output is high. Offset 0x04 reads 1, offset 0x0C reads 0, offset 0x14 reads 1 and offset 0x10 reads 0.
- R2: A write to offset 0x00 stores bits 7:0 as the payload, and a read of offset 0x00 returns 0. A write of bit 0 = 1 to offset 0x04 starts a frame at the clock edge that accepts the write. The start bit (low) is driven for CLKS_PER_BIT cycles. Then data bits 0 to 7 are driven in order, each for CLKS_PER_BIT cycles. Then the stop bit (high) is driven for CLKS_PER_BIT cycles.
- R3: Bit 0 of offset 0x04 reads 0 from the start edge until exactly 10*CLKS_PER_BIT cycles after it, and reads 1 from that point on.
- R4: A start write is ignored in two cases: when it arrives while a frame is in progress, or when its bit 0 is 0. In both cases the frame on the line is unchanged, and no further frame follows.
- R5: A read of offset 0x08 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte. Bytes come out in the order they arrived.
- R6: Offset 0x0C reads the number of bytes held in the receive FIFO.
- R7: Offset 0x10 reads 1 when the FIFO holds exactly one byte, and reads 0 otherwise.
- R8: Offset 0x14 reads 1 when the FIFO is empty, and reads 0 otherwise.
- R9: A byte that completes while the FIFO holds FIFO_DEPTH entries is dropped. The bytes already held are unchanged.
- R10: A read of offset 0x08 while the FIFO is empty returns 0 and changes neither the occupancy nor any later data.
- R11: The receiver ignores a low pulse shorter than half a bit time. It discards a frame whose stop bit samples low, and it then receives the next well-formed frame correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| txLine | output | 1 | Serial transmit line, idles high |
| rxLine | input | 1 | Serial receive line, asynchronous |

## Verification
Register reads are due in the same cycle as the access. The bench therefore drives an access at a falling edge and samples the read data a step later. Pops and writes are checked with a further read after the rising edge that accepts them. On the transmit side, each bit is due in a window of cycles measured from the start edge, CLKS_PER_BIT cycles per bit. The bench counts clock edges from that start edge and samples each bit at its middle. It checks the ready flag one cycle before it is due to change and again in the cycle it changes. Receive results depend on the synchronizer and on mid-bit sampling, so they are checked only after the whole frame and one further idle bit time, when the push is certain to have happened.

// File: rtl/uart_poll_pkg.sv
package uart_poll_pkg;
  localparam logic [7:0] OFS_TXDATA   = 8'h00;
  localparam logic [7:0] OFS_TXCTRL   = 8'h04;
  localparam logic [7:0] OFS_RXDATA   = 8'h08;
  localparam logic [7:0] OFS_RXCOUNT  = 8'h0C;
  localparam logic [7:0] OFS_RXALMOST = 8'h10;
  localparam logic [7:0] OFS_RXEMPTY  = 8'h14;

  typedef struct packed {
    logic loadPayload;
    logic startTx;
    logic popRx;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rxState_t;
endpackage

// File: rtl/uart_poll_fifo.sv
module uart_poll_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic doPush;
  logic doPop;

  assign doPush  = push && (count != CNT_W'(DEPTH));
  assign doPop   = pop && (count != '0);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_poll_dp.sv
module uart_poll_dp
  import uart_poll_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FIFO_DEPTH   = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int DATA_W       = 32,
  parameter int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txReady,
  output logic [CNT_W-1:0]  rxCount,
  output logic [7:0]        rxHead,
  output logic              rxPush
);
  localparam int DIV_W = $clog2(CLKS_PER_BIT);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLKS_PER_BIT / 2 - 1);

  logic unusedWdataHi;
  assign unusedWdataHi = ^wdata[DATA_W-1:8];

  // transmit side
  logic [7:0]       payload;
  logic [9:0]       txShift;
  logic [DIV_W-1:0] txDiv;
  logic [3:0]       txBit;
  logic             txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payload <= '0;
      txShift <= '1;
      txDiv   <= '0;
      txBit   <= '0;
      txBusy  <= 1'b0;
    end else begin
      if (strobes.loadPayload) payload <= wdata[7:0];
      if (!txBusy) begin
        if (strobes.startTx) begin
          txBusy  <= 1'b1;
          txShift <= {1'b1, payload, 1'b0};
          txDiv   <= '0;
          txBit   <= '0;
        end
      end else if (txDiv == DIV_LAST) begin
        txDiv <= '0;
        if (txBit == 4'd9) begin
          txBusy <= 1'b0;
        end else begin
          txBit   <= txBit + 1'b1;
          txShift <= {1'b1, txShift[9:1]};
        end
      end else begin
        txDiv <= txDiv + 1'b1;
      end
    end
  end

  assign txLine  = txBusy ? txShift[0] : 1'b1;
  assign txReady = !txBusy;

  // receive synchronizer chain
  logic [SYNC_STAGES-1:0] rxSync;
  logic rxBit;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) rxSync[s] <= 1'b1;
      else if (s == 0) rxSync[s] <= rxLine;
      else rxSync[s] <= rxSync[(s == 0) ? 0 : s - 1];
    end
  end
  assign rxBit = rxSync[SYNC_STAGES-1];

  // receive deserializer
  rxState_t         rxSt;
  logic [DIV_W-1:0] rxDiv;
  logic [2:0]       rxIdx;
  logic [7:0]       rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSt    <= RX_IDLE;
      rxDiv   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
      rxPush  <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      case (rxSt)
        RX_IDLE: begin
          rxDiv <= '0;
          if (!rxBit) rxSt <= RX_START;
        end
        RX_START: begin
          if (rxDiv == DIV_HALF) begin
            rxDiv <= '0;
            rxIdx <= '0;
            rxSt  <= rxBit ? RX_IDLE : RX_DATA;
          end else begin
            rxDiv <= rxDiv + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxDiv == DIV_LAST) begin
            rxDiv   <= '0;
            rxShift <= {rxBit, rxShift[7:1]};
            if (rxIdx == 3'd7) rxSt <= RX_STOP;
            else rxIdx <= rxIdx + 1'b1;
          end else begin
            rxDiv <= rxDiv + 1'b1;
          end
        end
        RX_STOP: begin
          if (rxDiv == DIV_LAST) begin
            rxDiv <= '0;
            if (rxBit) begin
              rxPush <= 1'b1;
              rxSt   <= RX_IDLE;
            end else begin
              rxSt <= RX_HOLD;
            end
          end else begin
            rxDiv <= rxDiv + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rxBit) rxSt <= RX_IDLE;
        end
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

  uart_poll_fifo #(
    .DEPTH(FIFO_DEPTH),
    .WIDTH(8),
    .CNT_W(CNT_W)
  ) rxFifo_i (
    .clk     (clk),
    .rstN    (rstN),
    .push    (rxPush),
    .pushData(rxShift),
    .pop     (strobes.popRx),
    .popData (rxHead),
    .count   (rxCount)
  );
endmodule

// File: rtl/uart_poll_ctrl.sv
module uart_poll_ctrl
  import uart_poll_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              startBit,
  input  logic              txReady,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [7:0]        rxHead,
  output ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] busRdata
);
  logic isWr;
  logic isRd;
  logic [7:0] ofs;

  assign isWr = busValid && busWrite;
  assign isRd = busValid && !busWrite;
  assign ofs  = 8'(busAddr);

  always_comb begin
    strobes.loadPayload = isWr && (ofs == OFS_TXDATA);
    strobes.startTx     = isWr && (ofs == OFS_TXCTRL) && startBit;
    strobes.popRx       = isRd && (ofs == OFS_RXDATA);
  end

  always_comb begin
    busRdata = '0;
    if (isRd) begin
      case (ofs)
        OFS_TXCTRL:   busRdata = DATA_W'(txReady);
        OFS_RXDATA:   busRdata = (rxCount == '0) ? '0 : DATA_W'(rxHead);
        OFS_RXCOUNT:  busRdata = DATA_W'(rxCount);
        OFS_RXALMOST: busRdata = DATA_W'(rxCount == CNT_W'(1));
        OFS_RXEMPTY:  busRdata = DATA_W'(rxCount == '0);
        default:      busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_poll_top.sv
module uart_poll_top
  import uart_poll_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FIFO_DEPTH   = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txLine,
  input  logic              rxLine
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  ctrlStrobes_t     ctrlStr;
  logic             txReady;
  logic [CNT_W-1:0] rxCount;
  logic [7:0]       rxHead;
  logic             rxPush;

  uart_poll_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) ctrl_i (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .startBit(busWdata[0]),
    .txReady (txReady),
    .rxCount (rxCount),
    .rxHead  (rxHead),
    .strobes (ctrlStr),
    .busRdata(busRdata)
  );

  uart_poll_dp #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(ctrlStr),
    .wdata  (busWdata),
    .rxLine (rxLine),
    .txLine (txLine),
    .txReady(txReady),
    .rxCount(rxCount),
    .rxHead (rxHead),
    .rxPush (rxPush)
  );
endmodule

// File: rtl/uart_poll_chk.sv
module uart_poll_chk
  import uart_poll_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStrobes_t     strobes,
  input logic             txReady,
  input logic             txLine,
  input logic [CNT_W-1:0] rxCount,
  input logic             rxPush
);
  // R1: the line is high whenever the transmitter reports ready
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R3: an accepted start makes the port busy in the next cycle
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startTx && txReady) |=> (!txReady && !txLine));

  // R6: occupancy moves by at most one per cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == $past(rxCount)) || (rxCount == $past(rxCount) + CNT_W'(1)) ||
    (rxCount + CNT_W'(1) == $past(rxCount)));

  // R5: a pop with no push removes one entry
  a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popRx && rxCount != '0 && !rxPush) |=> (rxCount == $past(rxCount) - CNT_W'(1)));

  // R10: a pop of an empty FIFO changes nothing
  a_r10_empty_read_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popRx && rxCount == '0 && !rxPush) |=> (rxCount == '0));

  // R9: a push into a full FIFO is dropped
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxCount == CNT_W'(FIFO_DEPTH) && !strobes.popRx) |=> (rxCount == CNT_W'(FIFO_DEPTH)));

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(FIFO_DEPTH));
endmodule

bind uart_poll_top uart_poll_chk #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .CNT_W     (CNT_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .strobes(ctrlStr),
  .txReady(txReady),
  .txLine (txLine),
  .rxCount(rxCount),
  .rxPush (rxPush)
);

// File: tb/uart_poll_top_tb_top.sv
module uart_poll_top_tb_top;
  localparam int CPB   = 16;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txLine;
  logic        rxLine = 1'b1;

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_poll_top #(
    .CLKS_PER_BIT(CPB),
    .FIFO_DEPTH  (DEPTH)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .txLine  (txLine),
    .rxLine  (rxLine)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic expTxBit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic peekAt(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic readPop(output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 8'h08;
    #1 d = busRdata;
    @(posedge clk);
    #1 busValid = 1'b0;
  endtask

  task automatic waitCyc(input int t);
    do @(negedge clk); while (cyc < t);
  endtask

  task automatic checkStatus(input int expCount, input string ctx);
    logic [31:0] d;
    peekAt(8'h0C, d); check({"R6 count ", ctx}, d, 32'(expCount));
    peekAt(8'h10, d); check({"R7 almost ", ctx}, d, 32'(expCount == 1));
    peekAt(8'h14, d); check({"R8 empty ", ctx}, d, 32'(expCount == 0));
  endtask

  task automatic txFrame(input logic [7:0] b, input bit poke);
    logic [31:0] d;
    int n0;
    writeReg(8'h00, {24'h0, b});
    peekAt(8'h00, d); check("R2 payload reads zero", d, 32'h0);
    writeReg(8'h04, 32'h1);
    n0 = cyc;
    waitCyc(n0 + 1); peek(8'h04, d); check("R3 busy after start", d, 32'h0);
    for (int k = 0; k < 10; k++) begin
      waitCyc(n0 + k * CPB + CPB / 2);
      check($sformatf("R2 tx bit %0d", k), 32'(txLine), 32'(expTxBit(b, k)));
      if (poke && k == 2) begin
        writeReg(8'h00, {24'h0, ~b});
        writeReg(8'h04, 32'h1);
      end
    end
    waitCyc(n0 + 10 * CPB - 1); peek(8'h04, d); check("R3 busy last cycle", d, 32'h0);
    waitCyc(n0 + 10 * CPB);     peek(8'h04, d); check("R3 ready at end", d, 32'h1);
    if (poke) begin
      logic sawLow = 1'b0;
      for (int i = 0; i < 2 * CPB; i++) begin
        @(negedge clk);
        if (!txLine) sawLow = 1'b1;
      end
      check("R4 no frame after busy start", 32'(sawLow), 32'h0);
    end
  endtask

  task automatic rxSend(input logic [7:0] b, input logic stopVal);
    logic [9:0] f;
    f = {stopVal, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rxLine = f[k];
      repeat (CPB - 1) @(negedge clk);
    end
    @(negedge clk);
    rxLine = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  q [5];
    void'($urandom(32'h5eed1234));

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peekAt(8'h04, d); check("R1 ready after reset", d, 32'h1);
    check("R1 line high", 32'(txLine), 32'h1);
    checkStatus(0, "after reset R1");

    // R2 R3 transmit frames
    txFrame(8'hA5, 1'b0);
    txFrame(8'h01, 1'b0);
    for (int i = 0; i < 3; i++) txFrame(8'($urandom), 1'b0);

    // R4 start while busy
    txFrame(8'($urandom), 1'b1);

    // R4 start with bit 0 clear
    writeReg(8'h04, 32'h2);
    begin
      logic sawLow = 1'b0;
      for (int i = 0; i < 2 * CPB; i++) begin
        @(negedge clk);
        if (!txLine) sawLow = 1'b1;
      end
      check("R4 bit0 clear no frame", 32'(sawLow), 32'h0);
    end
    peekAt(8'h04, d); check("R4 still ready", d, 32'h1);

    // R5 single bytes received and drained
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (i == 0) b = 8'h80;
      if (i == 1) b = 8'h01;
      rxSend(b, 1'b1);
      checkStatus(1, "one byte");
      readPop(d); check("R5 rx data", d, {24'h0, b});
      checkStatus(0, "after pop");
    end

    // R10 read while empty
    readPop(d); check("R10 empty read value", d, 32'h0);
    checkStatus(0, "R10 after empty read");

    // R9 overfill by one, then drain in order
    for (int i = 0; i < 5; i++) begin
      q[i] = 8'($urandom);
      rxSend(q[i], 1'b1);
      if (i == 1) checkStatus(2, "two held");
    end
    checkStatus(DEPTH, "R9 full");
    for (int i = 0; i < DEPTH; i++) begin
      readPop(d); check($sformatf("R9 R5 order %0d", i), d, {24'h0, q[i]});
      checkStatus(DEPTH - 1 - i, "draining");
    end
    readPop(d); check("R9 dropped byte absent", d, 32'h0);

    // R11 short glitch
    @(negedge clk); rxLine = 1'b0;
    repeat (3) @(negedge clk); rxLine = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    checkStatus(0, "R11 glitch");

    // R11 bad stop bit, then recovery
    rxSend(8'h3C, 1'b0);
    checkStatus(0, "R11 bad stop");
    rxSend(8'hC3, 1'b1);
    checkStatus(1, "R11 recovery");
    readPop(d); check("R11 recovered data", d, 32'h000000C3);

    summary();
  end
endmodule